// File: doc/BRIEF.md
# Split-Ring Descriptor Chain Walker

This block pulls one request out of a split virtqueue that lives in system memory. From a page number and a power-of-two queue size it works out where the descriptor table, the available ring and the used ring sit. On a start pulse it reads the guest's published available index. If there is work, it reads the next available-ring slot to get a head index and then follows the linked descriptors from that head. Each descriptor comes out as one segment on a stream, tagged as device-writable (in) or device-readable (out), with its buffer address and byte length.

Memory is reached through a request channel and a response channel. Both use valid/ready. Responses return in order, and the walker keeps at most one read in flight. The request side holds `mrd_valid` and `mrd_addr` steady until `mrd_ready` is seen. The walker raises `mrs_ready` only while it waits for a response. The segment stream follows the same back-pressure rules: once `seg_valid` rises, it stays high and `seg_write`, `seg_addr` and `seg_len` stay fixed until a cycle in which `seg_ready` is high. A one-cycle `done` pulse closes every fetch. The result fields (`fetched`, `head_id`, `loop_err`, `n_in`, `n_out`) then hold until the next start. A start pulse is only taken while the walker is idle.

Top module: `vq_chain_walker`

## Requirements
- R1: `desc_base` equals `cfg_page` shifted left by 12 (4096-byte pages).
- R2: `avail_base` equals `desc_base + 16*cfg_qsize`. `used_base` is the first 4096-byte boundary at or after `avail_base + 4 + 2*cfg_qsize`.
- R3: The guest index is the 16-bit word at `avail_base + 2`. If it equals `avail_ptr`, the fetch ends with `fetched`=0, `n_in`=`n_out`=0, no segment emitted and `avail_ptr` unchanged.
- R4: The ring slot read is at `avail_base + 4 + 2*(avail_ptr mod cfg_qsize)`. Descriptor k is read as 16 bytes at `desc_base + 16*(k mod cfg_qsize)`. Descriptor layout, little-endian: address in bytes 0-7, length in bytes 8-11, flags in bytes 12-13, next field in bytes 14-15.
- R5: `head_id` returns the raw 16-bit slot value. `avail_ptr` (reset 0) advances by exactly one per non-empty fetch only when `remove` was high with `start`.
- R6: A descriptor with flags bit 1 set is emitted with `seg_write`=1 and counted in `n_in`. Otherwise it is emitted with `seg_write`=0 and counted in `n_out`.
- R7: While flags bit 0 is set, the walk continues to the descriptor named by the next field. When it is clear, the walk ends.
- R8: Once `n_in + n_out` reaches `MAX_SEGS` (default 16), no further descriptor is read, `loop_err` is set and the fetch ends.
- R9: Segment stream back-pressure: while `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_write`, `seg_addr` and `seg_len` hold.
- R10: A read request holds its valid and address until accepted, and no new request is issued while a response is pending.
- R11: After reset, `done`, `seg_valid`, `mrd_valid`, `fetched` and `loop_err` are 0 and `avail_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page | input | PAGE_W | Page number of the descriptor table |
| cfg_qsize | input | 16 | Queue size, power of two |
| start | input | 1 | Begin one fetch (taken when idle) |
| remove | input | 1 | Consume the entry (sampled with start) |
| done | output | 1 | One-cycle end-of-fetch pulse |
| fetched | output | 1 | Last fetch found a request |
| head_id | output | 16 | Request identifier (head index) |
| loop_err | output | 1 | Chain cut at the segment limit |
| n_in | output | CNT_W | Device-writable segment count |
| n_out | output | CNT_W | Device-readable segment count |
| avail_ptr | output | 16 | Device's next-available index |
| desc_base | output | ADDR_W | Descriptor table address |
| avail_base | output | ADDR_W | Available ring address |
| used_base | output | ADDR_W | Used ring address |
| mrd_valid | output | 1 | Read request valid |
| mrd_ready | input | 1 | Read request accepted |
| mrd_addr | output | ADDR_W | Read byte address |
| mrs_valid | input | 1 | Read response valid |
| mrs_ready | output | 1 | Walker accepts response |
| mrs_data | input | 128 | 16 bytes from the request address, byte 0 in bits 7:0 |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Segment accepted |
| seg_write | output | 1 | 1 = device-writable segment |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment byte length |

## Verification
The bench targets these cases:
- **Empty queue.** A walker that ignored emptiness would emit a stale chain and move its pointer.
- **Peek versus consume.** Fetches with `remove` low must repeat the same head.
- **Slot value outside the queue size.** A walker missing the modulo would read a descriptor past the table.
- **Ring pointer passing the queue size.** A walker missing the modulo would read past the ring.
- **Two descriptors linked into a cycle.** A walker without the cap never finishes; one with an off-by-one cap reports a wrong count.
- **Held segment ready and a stalling memory port.** These expose segments that change or vanish under back-pressure, and requests that are dropped.

// File: rtl/vq_pkg.sv
package vq_pkg;
  localparam int PAGE_SHIFT     = 12;
  localparam int DESC_SHIFT     = 4;
  localparam int AVAIL_IDX_OFS  = 2;
  localparam int AVAIL_RING_OFS = 4;
  localparam int IDX_W          = 16;
  localparam int BEAT_W         = 128;
  localparam int FLAG_NEXT_BIT  = 0;
  localparam int FLAG_WRITE_BIT = 1;

  typedef enum logic [3:0] {
    WS_IDLE,
    WS_IDX_REQ,
    WS_IDX_WAIT,
    WS_ENT_REQ,
    WS_ENT_WAIT,
    WS_DESC_REQ,
    WS_DESC_WAIT,
    WS_EMIT,
    WS_FIN
  } walk_state_e;

  typedef struct packed {
    logic [15:0] link;
    logic [15:0] flags;
    logic [31:0] len;
    logic [63:0] addr;
  } desc_t;
endpackage

// File: rtl/vq_layout.sv
module vq_layout
  import vq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PAGE_W = 32
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [IDX_W-1:0]  qsize,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] avail_base,
  output logic [ADDR_W-1:0] used_base
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

  logic [ADDR_W-1:0] qsz_w;
  logic [ADDR_W-1:0] avail_end;

  always_comb begin
    qsz_w      = ADDR_W'(qsize);
    desc_base  = ADDR_W'(page) << PAGE_SHIFT;
    avail_base = desc_base + (qsz_w << DESC_SHIFT);
    avail_end  = avail_base + ADDR_W'(AVAIL_RING_OFS) + (qsz_w << 1);
    used_base  = (avail_end + PAGE_MASK) & ~PAGE_MASK;
  end
endmodule

// File: rtl/vq_seg_tally.sv
module vq_seg_tally #(
  parameter int MAX_SEGS = 16,
  localparam int CNT_W = $clog2(MAX_SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bump,
  input  logic             bump_wr,
  output logic [CNT_W-1:0] n_in,
  output logic [CNT_W-1:0] n_out,
  output logic             full
);
  logic [CNT_W:0] total;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      n_in  <= '0;
      n_out <= '0;
    end else if (bump) begin
      if (bump_wr) n_in  <= n_in + 1'b1;
      else         n_out <= n_out + 1'b1;
    end
  end

  assign total = {1'b0, n_in} + {1'b0, n_out};
  assign full  = total >= (CNT_W + 1)'(MAX_SEGS);

  // R8: the walker never accepts a segment beyond the limit
  assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !full);
endmodule

// File: rtl/vq_walk_fsm.sv
module vq_walk_fsm
  import vq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MAX_SEGS = 16,
  localparam int CNT_W = $clog2(MAX_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  qsize,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] avail_base,
  input  logic              start,
  input  logic              remove,
  output logic              done,
  output logic              fetched,
  output logic [IDX_W-1:0]  head_id,
  output logic              loop_err,
  output logic [IDX_W-1:0]  avail_ptr,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrs_valid,
  output logic              mrs_ready,
  input  logic [BEAT_W-1:0] mrs_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic              seg_write,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len,
  output logic              tally_clr,
  output logic              tally_bump,
  input  logic              tally_full,
  input  logic [CNT_W-1:0]  n_in,
  input  logic [CNT_W-1:0]  n_out
);
  walk_state_e      state;
  logic             rm_q;
  logic [IDX_W-1:0] cur_idx;
  desc_t            cur_q;
  logic [IDX_W-1:0] mask;
  logic             unused_flags;

  assign mask         = qsize - 1'b1;
  assign unused_flags = ^cur_q.flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      rm_q      <= 1'b0;
      cur_idx   <= '0;
      cur_q     <= '0;
      head_id   <= '0;
      fetched   <= 1'b0;
      loop_err  <= 1'b0;
      avail_ptr <= '0;
    end else begin
      unique case (state)
        WS_IDLE: if (start) begin
          rm_q     <= remove;
          fetched  <= 1'b0;
          loop_err <= 1'b0;
          state    <= WS_IDX_REQ;
        end
        WS_IDX_REQ:  if (mrd_ready) state <= WS_IDX_WAIT;
        WS_IDX_WAIT: if (mrs_valid) begin
          if (mrs_data[IDX_W-1:0] == avail_ptr) state <= WS_FIN;
          else                                  state <= WS_ENT_REQ;
        end
        WS_ENT_REQ:  if (mrd_ready) state <= WS_ENT_WAIT;
        WS_ENT_WAIT: if (mrs_valid) begin
          head_id <= mrs_data[IDX_W-1:0];
          cur_idx <= mrs_data[IDX_W-1:0];
          fetched <= 1'b1;
          if (rm_q) avail_ptr <= avail_ptr + 1'b1;
          state   <= WS_DESC_REQ;
        end
        WS_DESC_REQ: begin
          if (tally_full) begin
            loop_err <= 1'b1;
            state    <= WS_FIN;
          end else if (mrd_ready) begin
            state <= WS_DESC_WAIT;
          end
        end
        WS_DESC_WAIT: if (mrs_valid) begin
          cur_q <= desc_t'(mrs_data);
          state <= WS_EMIT;
        end
        WS_EMIT: if (seg_ready) begin
          if (cur_q.flags[FLAG_NEXT_BIT]) begin
            cur_idx <= cur_q.link;
            state   <= WS_DESC_REQ;
          end else begin
            state <= WS_FIN;
          end
        end
        WS_FIN:  state <= WS_IDLE;
        default: state <= WS_IDLE;
      endcase
    end
  end

  always_comb begin
    mrd_valid = 1'b0;
    mrd_addr  = '0;
    unique case (state)
      WS_IDX_REQ: begin
        mrd_valid = 1'b1;
        mrd_addr  = avail_base + ADDR_W'(AVAIL_IDX_OFS);
      end
      WS_ENT_REQ: begin
        mrd_valid = 1'b1;
        mrd_addr  = avail_base + ADDR_W'(AVAIL_RING_OFS)
                  + (ADDR_W'(avail_ptr & mask) << 1);
      end
      WS_DESC_REQ: begin
        mrd_valid = !tally_full;
        mrd_addr  = desc_base + (ADDR_W'(cur_idx & mask) << DESC_SHIFT);
      end
      default: ;
    endcase
  end

  assign mrs_ready  = (state == WS_IDX_WAIT) || (state == WS_ENT_WAIT)
                   || (state == WS_DESC_WAIT);
  assign seg_valid  = (state == WS_EMIT);
  assign seg_write  = cur_q.flags[FLAG_WRITE_BIT];
  assign seg_addr   = cur_q.addr;
  assign seg_len    = cur_q.len;
  assign done       = (state == WS_FIN);
  assign tally_clr  = (state == WS_IDLE) && start;
  assign tally_bump = seg_valid && seg_ready;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));

  assert_no_req_while_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_ready |-> !mrd_valid);

  assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr)
                                && $stable(seg_len) && $stable(seg_write));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (avail_ptr == $past(avail_ptr)) || (avail_ptr == $past(avail_ptr) + 1'b1));

  assert_empty_no_segs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fetched |-> (n_in == '0) && (n_out == '0));
endmodule

// File: rtl/vq_chain_walker.sv
module vq_chain_walker
  import vq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PAGE_W = 32,
  parameter int MAX_SEGS = 16,
  localparam int CNT_W = $clog2(MAX_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [15:0]       cfg_qsize,
  input  logic              start,
  input  logic              remove,
  output logic              done,
  output logic              fetched,
  output logic [15:0]       head_id,
  output logic              loop_err,
  output logic [CNT_W-1:0]  n_in,
  output logic [CNT_W-1:0]  n_out,
  output logic [15:0]       avail_ptr,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] avail_base,
  output logic [ADDR_W-1:0] used_base,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrs_valid,
  output logic              mrs_ready,
  input  logic [127:0]      mrs_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic              seg_write,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len
);
  logic tally_clr, tally_bump, tally_full;

  vq_layout #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_layout (
    .page       (cfg_page),
    .qsize      (cfg_qsize),
    .desc_base  (desc_base),
    .avail_base (avail_base),
    .used_base  (used_base)
  );

  vq_seg_tally #(.MAX_SEGS(MAX_SEGS)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tally_clr),
    .bump    (tally_bump),
    .bump_wr (seg_write),
    .n_in    (n_in),
    .n_out   (n_out),
    .full    (tally_full)
  );

  vq_walk_fsm #(.ADDR_W(ADDR_W), .MAX_SEGS(MAX_SEGS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .qsize      (cfg_qsize),
    .desc_base  (desc_base),
    .avail_base (avail_base),
    .start      (start),
    .remove     (remove),
    .done       (done),
    .fetched    (fetched),
    .head_id    (head_id),
    .loop_err   (loop_err),
    .avail_ptr  (avail_ptr),
    .mrd_valid  (mrd_valid),
    .mrd_ready  (mrd_ready),
    .mrd_addr   (mrd_addr),
    .mrs_valid  (mrs_valid),
    .mrs_ready  (mrs_ready),
    .mrs_data   (mrs_data),
    .seg_valid  (seg_valid),
    .seg_ready  (seg_ready),
    .seg_write  (seg_write),
    .seg_addr   (seg_addr),
    .seg_len    (seg_len),
    .tally_clr  (tally_clr),
    .tally_bump (tally_bump),
    .tally_full (tally_full),
    .n_in       (n_in),
    .n_out      (n_out)
  );

  // R11: nothing is requested or emitted in the first cycle after reset
  assert_quiet_after_reset_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> !mrd_valid && !seg_valid && !done);
endmodule

// File: tb/vq_chain_walker_tb_top.sv
module vq_chain_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        rm;
    logic [15:0] gidx;
    logic        exp_f;
    logic [15:0] exp_head;
    logic [4:0]  exp_in;
    logic [4:0]  exp_out;
    logic        exp_loop;
    logic [15:0] exp_ptr;
    logic [31:0] first_len;
  } vec_t;

  // descriptor k has length 10*(k+1); ring slots: 0,3,4,6,11,0,3,4
  localparam vec_t VECS [12] = '{
    '{1'b1, 16'd0,  1'b0, 16'd0,  5'd0, 5'd0,  1'b0, 16'd0, 32'd0},
    '{1'b0, 16'd6,  1'b1, 16'd0,  5'd2, 5'd1,  1'b0, 16'd0, 32'd10},
    '{1'b1, 16'd6,  1'b1, 16'd0,  5'd2, 5'd1,  1'b0, 16'd1, 32'd10},
    '{1'b1, 16'd6,  1'b1, 16'd3,  5'd0, 5'd1,  1'b0, 16'd2, 32'd40},
    '{1'b1, 16'd6,  1'b1, 16'd4,  5'd2, 5'd0,  1'b0, 16'd3, 32'd50},
    '{1'b1, 16'd6,  1'b1, 16'd6,  5'd0, 5'd16, 1'b1, 16'd4, 32'd70},
    '{1'b1, 16'd6,  1'b1, 16'd11, 5'd0, 5'd1,  1'b0, 16'd5, 32'd40},
    '{1'b1, 16'd5,  1'b0, 16'd0,  5'd0, 5'd0,  1'b0, 16'd5, 32'd0},
    '{1'b1, 16'd14, 1'b1, 16'd0,  5'd2, 5'd1,  1'b0, 16'd6, 32'd10},
    '{1'b1, 16'd14, 1'b1, 16'd3,  5'd0, 5'd1,  1'b0, 16'd7, 32'd40},
    '{1'b1, 16'd14, 1'b1, 16'd4,  5'd2, 5'd0,  1'b0, 16'd8, 32'd50},
    '{1'b1, 16'd14, 1'b1, 16'd0,  5'd2, 5'd1,  1'b0, 16'd9, 32'd10}
  };

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_page = 0;
  logic [15:0] cfg_qsize = 16'd8;
  logic start = 0, remove = 0, seg_ready = 1;
  logic done, fetched, loop_err, mrd_valid, mrd_ready, mrs_valid, mrs_ready;
  logic seg_valid, seg_write;
  logic [15:0] head_id, avail_ptr;
  logic [4:0] n_in, n_out;
  logic [63:0] desc_base, avail_base, used_base, mrd_addr, seg_addr;
  logic [31:0] seg_len;
  logic [127:0] mrs_data;

  logic [7:0] mem [0:511];
  logic rsp_pend = 0;
  logic [63:0] rsp_addr = 0;
  int cyc = 0, bad_addr = 0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vq_chain_walker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_page(cfg_page), .cfg_qsize(cfg_qsize),
    .start(start), .remove(remove), .done(done), .fetched(fetched),
    .head_id(head_id), .loop_err(loop_err), .n_in(n_in), .n_out(n_out),
    .avail_ptr(avail_ptr), .desc_base(desc_base), .avail_base(avail_base),
    .used_base(used_base), .mrd_valid(mrd_valid), .mrd_ready(mrd_ready),
    .mrd_addr(mrd_addr), .mrs_valid(mrs_valid), .mrs_ready(mrs_ready),
    .mrs_data(mrs_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_write(seg_write), .seg_addr(seg_addr), .seg_len(seg_len)
  );

  // memory model: one response per accepted request, request side stalls
  assign mrd_ready = !rsp_pend && (cyc % 3 != 0);
  assign mrs_valid = rsp_pend;
  always_comb
    for (int b = 0; b < 16; b++)
      mrs_data[8*b +: 8] = mem[9'(rsp_addr[8:0] + 9'(b))];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) rsp_pend <= 1'b0;
    else begin
      if (mrs_valid && mrs_ready) rsp_pend <= 1'b0;
      if (mrd_valid && mrd_ready) begin
        rsp_pend <= 1'b1;
        rsp_addr <= mrd_addr;
        // R4: legal targets are guest index, ring slots, descriptor slots
        if (!(mrd_addr == 64'd130 ||
              (mrd_addr >= 64'd132 && mrd_addr <= 64'd146 && !mrd_addr[0]) ||
              (mrd_addr < 64'd128 && mrd_addr[3:0] == 4'd0)))
          bad_addr <= bad_addr + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put16(input int a, input logic [15:0] v);
    mem[a] = v[7:0];
    mem[a+1] = v[15:8];
  endtask

  task automatic put_desc(input int k, input logic [63:0] ad, input logic [31:0] ln,
                          input logic [15:0] fl, input logic [15:0] nx);
    for (int b = 0; b < 8; b++) mem[16*k + b] = ad[8*b +: 8];
    for (int b = 0; b < 4; b++) mem[16*k + 8 + b] = ln[8*b +: 8];
    put16(16*k + 12, fl);
    put16(16*k + 14, nx);
  endtask

  int s_in, s_out;
  logic [31:0] s_first;
  bit got_done;

  task automatic run_fetch(input logic rm, input logic [15:0] gidx);
    put16(130, gidx);
    s_in = 0; s_out = 0; s_first = 0; got_done = 0;
    @(negedge clk); start = 1; remove = rm;
    @(negedge clk); start = 0; remove = 0;
    for (int t = 0; t < 3000; t++) begin
      if (seg_valid && seg_ready) begin
        if (s_in + s_out == 0) s_first = seg_len;
        if (seg_write) s_in++; else s_out++;
      end
      if (done) begin got_done = 1; break; end
      @(negedge clk);
    end
    check(got_done, "R8", "fetch finished", 64'(got_done), 1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    // flags: bit0 = continue, bit1 = device-writable
    put_desc(0, 64'h1000, 32'd10, 16'h1, 16'd1);
    put_desc(1, 64'h2000, 32'd20, 16'h3, 16'd2);
    put_desc(2, 64'h3000, 32'd30, 16'h2, 16'd0);
    put_desc(3, 64'h4000, 32'd40, 16'h0, 16'd0);
    put_desc(4, 64'h5000, 32'd50, 16'h3, 16'd5);
    put_desc(5, 64'h6000, 32'd60, 16'h2, 16'd0);
    put_desc(6, 64'h7000, 32'd70, 16'h1, 16'd7);
    put_desc(7, 64'h8000, 32'd80, 16'h1, 16'd6);
    put16(132, 0); put16(134, 3); put16(136, 4); put16(138, 6);
    put16(140, 11); put16(142, 0); put16(144, 3); put16(146, 4);

    repeat (3) @(negedge clk);
    // R11 reset state
    check(!done && !seg_valid && !mrd_valid && !fetched && !loop_err, "R11",
          "outputs quiet in reset", 64'({done, seg_valid, mrd_valid, fetched, loop_err}), 0);
    check(avail_ptr == 0, "R11", "avail_ptr reset", 64'(avail_ptr), 0);
    rst_n = 1;
    @(negedge clk);
    check(!mrd_valid && !seg_valid, "R11", "idle after reset", 64'({mrd_valid, seg_valid}), 0);

    // R1 / R2 layout
    check(desc_base == 64'h0, "R1", "desc_base page0", 64'(desc_base), 0);
    check(avail_base == 64'd128, "R2", "avail_base q8", 64'(avail_base), 128);
    check(used_base == 64'h1000, "R2", "used_base q8", 64'(used_base), 64'h1000);
    cfg_page = 3; cfg_qsize = 16'd256;
    #1;
    check(desc_base == 64'h3000, "R1", "desc_base page3", 64'(desc_base), 64'h3000);
    check(avail_base == 64'h4000, "R2", "avail_base q256", 64'(avail_base), 64'h4000);
    check(used_base == 64'h5000, "R2", "used_base q256", 64'(used_base), 64'h5000);
    cfg_page = 0; cfg_qsize = 16'd8;
    @(negedge clk);

    // vector table: R3 empty, R5 peek/consume, R6 sorting, R7 chains, R8 loop, R4 wrap
    foreach (VECS[i]) begin
      run_fetch(VECS[i].rm, VECS[i].gidx);
      check(fetched == VECS[i].exp_f, "R3", $sformatf("v%0d fetched", i),
            64'(fetched), 64'(VECS[i].exp_f));
      if (VECS[i].exp_f)
        check(head_id == VECS[i].exp_head, "R5", $sformatf("v%0d head_id", i),
              64'(head_id), 64'(VECS[i].exp_head));
      check(n_in == VECS[i].exp_in && s_in == int'(VECS[i].exp_in), "R6",
            $sformatf("v%0d in count", i), 64'(n_in), 64'(VECS[i].exp_in));
      check(n_out == VECS[i].exp_out && s_out == int'(VECS[i].exp_out), "R7",
            $sformatf("v%0d out count", i), 64'(n_out), 64'(VECS[i].exp_out));
      check(loop_err == VECS[i].exp_loop, "R8", $sformatf("v%0d loop_err", i),
            64'(loop_err), 64'(VECS[i].exp_loop));
      check(avail_ptr == VECS[i].exp_ptr, "R5", $sformatf("v%0d avail_ptr", i),
            64'(avail_ptr), 64'(VECS[i].exp_ptr));
      check(s_first == VECS[i].first_len, "R4", $sformatf("v%0d first length", i),
            64'(s_first), 64'(VECS[i].first_len));
    end

    // R9 back-pressure: slot 1 -> descriptor 3, held for five cycles
    put16(130, 16'd15);
    seg_ready = 0;
    @(negedge clk); start = 1; remove = 1;
    @(negedge clk); start = 0; remove = 0;
    for (int t = 0; t < 200 && !seg_valid; t++) @(negedge clk);
    check(seg_valid, "R9", "segment offered", 64'(seg_valid), 1);
    repeat (5) @(negedge clk);
    check(seg_valid && seg_addr == 64'h4000 && seg_len == 32'd40 && !seg_write, "R9",
          "segment held under stall", 64'(seg_addr), 64'h4000);
    seg_ready = 1;
    for (int t = 0; t < 200 && !done; t++) @(negedge clk);
    check(done && n_out == 1 && n_in == 0, "R9", "single segment delivered", 64'(n_out), 1);
    check(avail_ptr == 16'd10, "R5", "pointer after stalled fetch", 64'(avail_ptr), 10);

    check(bad_addr == 0, "R4", "read addresses in legal slots", 64'(bad_addr), 0);
    check(bad_addr == 0 && n_run > 0, "R10", "memory port completed all reads", 64'(bad_addr), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule